// File: doc/BRIEF.md
# Self-Centering Bit Elastic Buffer

This block absorbs phase wander between a bit stream arriving on a recovered-clock enable and the same stream leaving on a smoothed-clock enable. Both enables are sampled in one system clock domain. Bits are stored in a circular buffer of `DEPTH` one-bit cells, where `DEPTH` is a power of two. A fill counter, published on `fill_lvl`, gives the distance between the write and read pointers.

A three-state centering controller guards the read pointer. In **BYPASS**, centering is off and the stream passes through unchanged, even when the buffer runs completely empty or completely full. **BYPASS → RECENTER** is taken when the centering enable is seen set, which is a 0-to-1 change of that bit. **RECENTER** lasts one cycle. In that cycle the read pointer is placed `DEPTH/2` cells behind the write pointer and any read request is ignored. **RECENTER → TRACK** is taken when centering is still enabled, and **RECENTER → BYPASS** when it is not. **TRACK** watches the margin. **TRACK → RECENTER** is taken when the fill reaches `MARGIN` (4) or `DEPTH-MARGIN`. **TRACK → BYPASS** is taken when centering is disabled.

Writing into a full buffer and reading from an empty one are counted as overrun and underrun events. Each event sets a sticky status bit that clears when the status register is read, and each bit can be routed to a shared interrupt. In limit mode, two level requests ask an external clock smoother to speed up or slow down when the fill comes within `LIMIT_UI` (1) of full or empty. A small register port holds the control word (select 0) and the status word (select 1).

Top module: `jat_fifo`

## Requirements
- R1: With centering disabled, bits leave in write order. A read accepted at a clock edge shows its bit on `rd_bit` after that edge, and `rd_bit` holds otherwise. The fill may reach 0 and `DEPTH` without any re-centering.
- R2: A control write that changes centering enable (bit 4) from 0 to 1 forces `fill_lvl` to `DEPTH/2` two edges after the write edge, whatever the fill was. The fill is unchanged one edge after the write.
- R3: While centering stays enabled, a fill that reaches `MARGIN` or `DEPTH-MARGIN` is returned to `DEPTH/2` two edges later. In the tracking state the fill never lies outside `MARGIN..DEPTH-MARGIN`.
- R4: A write request while the fill is `DEPTH` and no read is requested is dropped. It sets overrun status (status bit 1), and the fill stays `DEPTH`.
- R5: A read request while the fill is 0 drives `rd_bit` to 0 after the edge and sets underrun status (status bit 0).
- R6: Reading the status register clears both status bits at that edge. If an event occurs at the same edge, its bit stays set.
- R7: `irq` is high exactly while (overrun status AND control bit 2) OR (underrun status AND control bit 3).
- R8: With limit enable (control bit 0) set, `speed_up` is high while fill ≥ `DEPTH-1` and `slow_down` is high while fill ≤ 1. Both are low otherwise, and both are low whenever limit enable is clear.
- R9: After reset all control and status bits are 0, and the fill is 0. Control reads back bits 4, 3, 2 and 0 with every other bit 0. Writes to select 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Recovered-clock enable: store `wr_bit` |
| wr_bit | input | 1 | Incoming serial bit |
| rd_en | input | 1 | Smoothed-clock enable: fetch next bit |
| rd_bit | output | 1 | Outgoing serial bit (registered) |
| fill_lvl | output | $clog2(DEPTH+1) | Bits currently held |
| speed_up | output | 1 | Request a faster smoothed clock (near full) |
| slow_down | output | 1 | Request a slower smoothed clock (near empty) |
| irq | output | 1 | Active-high shared interrupt |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
Fill, `rd_bit` and sticky status change at the edge that takes the request. `speed_up`, `slow_down` and `irq` follow within that same cycle. A centering action lands two edges after its trigger: one edge enters RECENTER and the next sets the fill. The bench drives inputs 1 ns after a rising edge and reads fill, requests and register data straight after the following edge. A monitor compares each queued expected output bit at the falling edge after the read edge, and centering checks sample both the cycle before the action and the cycle it lands.

// File: rtl/jat_pkg.sv
package jat_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS   = 2'd0,
        ST_TRACK    = 2'd1,
        ST_RECENTER = 2'd2
    } ctr_state_e;

    typedef struct packed {
        logic cen;
        logic und_ie;
        logic ovr_ie;
        logic lim_en;
    } jat_ctrl_t;

    localparam int CTL_CEN_BIT = 4;
    localparam int CTL_UIE_BIT = 3;
    localparam int CTL_OIE_BIT = 2;
    localparam int CTL_LIM_BIT = 0;
    localparam int STS_OVR_BIT = 1;
    localparam int STS_UND_BIT = 0;

endpackage

// File: rtl/jat_bit_buffer.sv
module jat_bit_buffer #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    input  logic          recenter,
    output logic          rd_bit,
    output logic [CW-1:0] fill,
    output logic          ovr_evt,
    output logic          und_evt
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
    localparam logic [AW-1:0] HALF_P = AW'(DEPTH / 2);

    logic [DEPTH-1:0] cells;
    logic [AW-1:0]    wptr_q, rptr_q, wptr_nx;
    logic [CW-1:0]    cnt_q;
    logic             wr_ok, rd_ok, is_full, is_empty;

    assign is_full  = (cnt_q == FULL_C);
    assign is_empty = (cnt_q == '0);

    // Centering cycle: write always lands, read request is ignored.
    assign wr_ok   = wr_en && (recenter || !is_full || rd_en);
    assign rd_ok   = rd_en && !recenter && !is_empty;
    assign ovr_evt = wr_en && !recenter && is_full && !rd_en;
    assign und_evt = rd_en && !recenter && is_empty;
    assign wptr_nx = wptr_q + AW'(wr_ok);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= 1'b0;
            else if (wr_ok && (wptr_q == AW'(g)))
                cell_q <= wr_bit;
        end
        assign cells[g] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            wptr_q <= wptr_nx;
            if (recenter) begin
                rptr_q <= wptr_nx - HALF_P;
                cnt_q  <= HALF_C;
            end else begin
                rptr_q <= rptr_q + AW'(rd_ok);
                cnt_q  <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_bit <= 1'b0;
        else if (rd_ok)
            rd_bit <= cells[rptr_q];
        else if (und_evt)
            rd_bit <= 1'b0;
    end

    assign fill = cnt_q;

    assert_ovr_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> (fill == FULL_C));

    assert_und_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (und_evt && !wr_en) |=> (fill == '0 && rd_bit == 1'b0));

endmodule

// File: rtl/jat_center_fsm.sv
module jat_center_fsm
    import jat_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int MARGIN   = 4,
    parameter int LIMIT_UI = 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen,
    input  logic          lim_en,
    input  logic [CW-1:0] fill,
    output logic          recenter,
    output logic          speed_up,
    output logic          slow_down
);

    localparam logic [CW-1:0] LOW_C   = CW'(MARGIN);
    localparam logic [CW-1:0] HIGH_C  = CW'(DEPTH - MARGIN);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LIM_LO  = CW'(LIMIT_UI);
    localparam logic [CW-1:0] LIM_HI  = CW'(DEPTH - LIMIT_UI);

    ctr_state_e st_q, st_nx;
    logic       near_edge;

    assign near_edge = (fill <= LOW_C) || (fill >= HIGH_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_BYPASS;
        else
            st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_BYPASS:   if (cen) st_nx = ST_RECENTER;
            ST_TRACK: begin
                if (!cen)           st_nx = ST_BYPASS;
                else if (near_edge) st_nx = ST_RECENTER;
            end
            ST_RECENTER: st_nx = cen ? ST_TRACK : ST_BYPASS;
            default:     st_nx = ST_BYPASS;
        endcase
    end

    always_comb begin
        recenter  = (st_q == ST_RECENTER);
        speed_up  = lim_en && (fill >= LIM_HI);
        slow_down = lim_en && (fill <= LIM_LO);
    end

    assert_track_margin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK) |-> (fill >= LOW_C && fill <= HIGH_C));

    assert_recenter_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RECENTER) |=> (fill == HALF_C));

endmodule

// File: rtl/jat_ctrl_regs.sv
module jat_ctrl_regs
    import jat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    input  logic       ovr_evt,
    input  logic       und_evt,
    output jat_ctrl_t  ctrl,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    jat_ctrl_t ctrl_q;
    logic      sts_ovr_q, sts_und_q, sts_clr;

    assign sts_clr = reg_rd && reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && !reg_sel) begin
            ctrl_q.cen    <= reg_wdata[CTL_CEN_BIT];
            ctrl_q.und_ie <= reg_wdata[CTL_UIE_BIT];
            ctrl_q.ovr_ie <= reg_wdata[CTL_OIE_BIT];
            ctrl_q.lim_en <= reg_wdata[CTL_LIM_BIT];
        end
    end

    // A fresh event outranks a clearing read in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_ovr_q <= 1'b0;
            sts_und_q <= 1'b0;
        end else begin
            if (ovr_evt)      sts_ovr_q <= 1'b1;
            else if (sts_clr) sts_ovr_q <= 1'b0;
            if (und_evt)      sts_und_q <= 1'b1;
            else if (sts_clr) sts_und_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[STS_OVR_BIT] = sts_ovr_q;
            reg_rdata[STS_UND_BIT] = sts_und_q;
        end else begin
            reg_rdata[CTL_CEN_BIT] = ctrl_q.cen;
            reg_rdata[CTL_UIE_BIT] = ctrl_q.und_ie;
            reg_rdata[CTL_OIE_BIT] = ctrl_q.ovr_ie;
            reg_rdata[CTL_LIM_BIT] = ctrl_q.lim_en;
        end
    end

    assign ctrl = ctrl_q;
    assign irq  = (sts_ovr_q && ctrl_q.ovr_ie) || (sts_und_q && ctrl_q.und_ie);

    assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> sts_ovr_q);

    assert_und_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        und_evt |=> sts_und_q);

    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !ovr_evt && !und_evt) |=> (!sts_ovr_q && !sts_und_q));

endmodule

// File: rtl/jat_fifo.sv
module jat_fifo
    import jat_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int MARGIN   = 4,
    parameter int LIMIT_UI = 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    output logic          rd_bit,
    output logic [CW-1:0] fill_lvl,
    output logic          speed_up,
    output logic          slow_down,
    output logic          irq,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata
);

    jat_ctrl_t ctrl;
    logic      recenter, ovr_evt, und_evt;

    jat_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .ovr_evt   (ovr_evt),
        .und_evt   (und_evt),
        .ctrl      (ctrl),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    jat_center_fsm #(
        .DEPTH    (DEPTH),
        .MARGIN   (MARGIN),
        .LIMIT_UI (LIMIT_UI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cen       (ctrl.cen),
        .lim_en    (ctrl.lim_en),
        .fill      (fill_lvl),
        .recenter  (recenter),
        .speed_up  (speed_up),
        .slow_down (slow_down)
    );

    jat_bit_buffer #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bit   (wr_bit),
        .rd_en    (rd_en),
        .recenter (recenter),
        .rd_bit   (rd_bit),
        .fill     (fill_lvl),
        .ovr_evt  (ovr_evt),
        .und_evt  (und_evt)
    );

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.ovr_ie && !ctrl.und_ie) |-> !irq);

endmodule

// File: tb/test_jat_fifo.sv
module test_jat_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
    logic          rd_bit, speed_up, slow_down, irq;
    logic [CW-1:0] fill_lvl;
    logic          reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0, reg_rdata;

    int checks = 0;
    int errors = 0;
    bit sb_on  = 1'b1;
    bit        model_q[$];
    bit        exp_bit_q[$];
    string     exp_tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    jat_fifo #(.DEPTH(DEPTH)) i_jat_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .rd_bit(rd_bit), .fill_lvl(fill_lvl), .speed_up(speed_up),
        .slow_down(slow_down), .irq(irq), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(string req, int got, int exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_q.delete();
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic do_write(bit b);
        wr_en = 1'b1;
        wr_bit = b;
        if (model_q.size() < DEPTH) model_q.push_back(b);
        tick();
        wr_en = 1'b0;
    endtask

    // Driver: issue a read and queue its expected output for the monitor.
    task automatic do_read();
        bit e;
        string t;
        if (model_q.size() > 0) begin
            e = model_q.pop_front();
            t = "R1";
        end else begin
            e = 1'b0;
            t = "R5";
        end
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        if (sb_on) begin
            exp_bit_q.push_back(e);
            exp_tag_q.push_back(t);
        end
    endtask

    task automatic reg_write(bit sel, logic [7:0] d);
        reg_sel = sel;
        reg_wdata = d;
        reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(bit sel, output logic [7:0] d);
        reg_sel = sel;
        reg_rd = 1'b1;
        #1;
        d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    // Monitor: compare each expected bit after the read edge has settled.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_bit_q.size() > 0) begin
                check(exp_tag_q.pop_front(), int'(rd_bit), int'(exp_bit_q.pop_front()),
                      "rd_bit");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        do_reset();

        // R9: reset state
        check("R9", int'(fill_lvl), 0, "fill after reset");
        check("R9", int'(irq), 0, "irq after reset");
        reg_read(1'b0, rv);
        check("R9", int'(rv), 0, "control after reset");
        reg_read(1'b1, rv);
        check("R9", int'(rv), 0, "status after reset");
        reg_write(1'b0, 8'hEE);
        reg_read(1'b0, rv);
        check("R9", int'(rv), 8'h0C, "control readback 0xEE");
        reg_write(1'b1, 8'hFF);
        reg_read(1'b1, rv);
        check("R9", int'(rv), 0, "status write ignored");
        reg_write(1'b0, 8'h00);

        // R1: in-order pass-through, bursts and concurrent read/write
        for (int i = 0; i < 10; i++) do_write(bit'((i * 5 + 1) % 3 == 0));
        check("R1", int'(fill_lvl), 10, "fill after 10 writes");
        for (int i = 0; i < 4; i++) do_read();
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1;
            wr_bit = bit'(i[0] ^ i[2]);
            model_q.push_back(wr_bit);
            do_read();
            wr_en = 1'b0;
        end
        check("R1", int'(fill_lvl), 6, "fill after concurrent stream");
        while (model_q.size() > 0) do_read();
        check("R1", int'(fill_lvl), 0, "fill reaches 0 without centering");

        // R5: underrun, masked then unmasked interrupt
        do_read();
        check("R5", int'(fill_lvl), 0, "fill stays 0 after underrun");
        check("R7", int'(irq), 0, "irq masked after underrun");
        reg_write(1'b0, 8'h08);
        check("R7", int'(irq), 1, "irq with underrun enable");
        reg_read(1'b1, rv);
        check("R5", int'(rv), 8'h01, "underrun status bit 0");
        check("R6", int'(irq), 0, "irq drops after status read");
        reg_read(1'b1, rv);
        check("R6", int'(rv), 0, "status cleared by read");

        // R6: event at the same edge as a clearing read wins
        reg_sel = 1'b1;
        reg_rd = 1'b1;
        rd_en = 1'b1;
        tick();
        reg_rd = 1'b0;
        rd_en = 1'b0;
        reg_read(1'b1, rv);
        check("R6", int'(rv), 8'h01, "event wins over same-cycle clear");
        reg_read(1'b1, rv);
        check("R6", int'(rv), 0, "cleared on next read");
        reg_write(1'b0, 8'h00);

        // R4: overrun drops the write and keeps the fill at DEPTH
        for (int i = 0; i < DEPTH; i++) do_write(bit'((i * 3) % 5 < 2));
        check("R1", int'(fill_lvl), DEPTH, "fill reaches DEPTH without centering");
        do_write(1'b1);
        check("R4", int'(fill_lvl), DEPTH, "fill after overrun");
        check("R7", int'(irq), 0, "irq masked after overrun");
        reg_write(1'b0, 8'h04);
        check("R7", int'(irq), 1, "irq with overrun enable");
        reg_read(1'b1, rv);
        check("R4", int'(rv), 8'h02, "overrun status bit 1");
        check("R7", int'(irq), 0, "irq after clear");
        while (model_q.size() > 0) do_read();
        reg_write(1'b0, 8'h00);

        // R8: limit requests near both ends
        reg_write(1'b0, 8'h01);
        check("R8", int'(slow_down), 1, "slow_down at fill 0");
        check("R8", int'(speed_up), 0, "speed_up at fill 0");
        do_write(1'b0);
        check("R8", int'(slow_down), 1, "slow_down at fill 1");
        do_write(1'b1);
        check("R8", int'(slow_down), 0, "slow_down at fill 2");
        check("R8", int'(speed_up), 0, "speed_up at fill 2");
        while (model_q.size() < DEPTH - 2) do_write(1'b1);
        check("R8", int'(speed_up), 0, "speed_up at fill DEPTH-2");
        do_write(1'b0);
        check("R8", int'(speed_up), 1, "speed_up at fill DEPTH-1");
        reg_write(1'b0, 8'h00);
        check("R8", int'(speed_up), 0, "speed_up off with limit disabled");

        // R2: rising centering enable at fill DEPTH-1
        sb_on = 1'b0;
        reg_write(1'b0, 8'h10);
        check("R2", int'(fill_lvl), DEPTH - 1, "fill one edge after enable");
        tick();
        check("R2", int'(fill_lvl), DEPTH - 1, "fill in centering cycle");
        tick();
        check("R2", int'(fill_lvl), DEPTH / 2, "fill after centering");

        // R3: margin near empty, then near full
        for (int i = 0; i < DEPTH / 2 - 4; i++) do_read();
        check("R3", int'(fill_lvl), 4, "fill reaches low margin");
        tick();
        check("R3", int'(fill_lvl), 4, "fill before low-side centering");
        tick();
        check("R3", int'(fill_lvl), DEPTH / 2, "fill after low-side centering");
        for (int i = 0; i < DEPTH / 2 - 4; i++) do_write(1'b1);
        check("R3", int'(fill_lvl), DEPTH - 4, "fill reaches high margin");
        tick();
        tick();
        check("R3", int'(fill_lvl), DEPTH / 2, "fill after high-side centering");

        sb_on = 1'b1;
        do_reset();
        check("R9", int'(fill_lvl), 0, "fill after second reset");

        repeat (3) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule